// File: doc/BRIEF.md
# Bidirectional Pad Crossbar

This block is the routing fabric between a chip's external pads and its internal logic. In the outbound direction, every pad has its own selector register. The selector names which internal source drives the pad: one bit of a GPIO output port or one peripheral output. In the inbound direction, every internal sink has its own selector register. A sink is one GPIO input bit or one peripheral input, and its selector names the pad that feeds it. Because inbound selection belongs to the sink and not to the pad, one pad can feed any number of sinks at the same time. For example, two GPIO bits can watch the same button, one set up for a rising edge and one for a falling edge.

All selectors share one code space, in which every pad and every source has a unique code. Each pad also has a control register with input-enable, pull-up and pull-down bits. A pad value is passed inward only when its input-enable bit is set. A GPIO that drives a pad can read its own pad level back by selecting that pad on its input bit. Software programs the crossbar through a simple word-addressed register bus.

Top module: `pinmux_xbar`

## Requirements
- R1: After a synchronous active-high reset, every selector and control register reads 0. All `pad_oe`, `pad_out`, `pad_pu`, `pad_pd`, `gpio_in` and `periph_in` bits are then 0.
- R2: Pad p has its selector at byte address 8*p and its control register at 8*p+4. The control bits are bit 0 input enable, bit 1 pull-up and bit 2 pull-down. `bus_rdata` returns the addressed register one cycle after `bus_addr` is presented. Unmapped addresses read 0.
- R3: The selector of GPIO input bit b of port n sits at GSINK_BASE (0x100) + 64*n + 4*b. The selector of peripheral input k sits at PSINK_BASE (0x200) + 4*k.
- R4: Selector codes are assigned as follows. Code 0 means unconnected. Pad p is code p+1. GPIO bit j = n*GPIO_WIDTH+b is code NUM_PADS+1+j. Peripheral output k is code NUM_PADS+1+NUM_GPIO+k. With the defaults, pads are 1..8, GPIO bits are 9..40 and peripheral outputs are 41..44.
- R5: A pad whose selector holds a GPIO code registers that bit's `gpio_out` as `pad_out` and its `gpio_oe` as `pad_oe`, one clock later.
- R6: A pad whose selector holds a peripheral code registers that output as `pad_out` with `pad_oe` = 1, one clock later.
- R7: A pad selector holding 0, a pad code or an unused code gives `pad_out` = 0 and `pad_oe` = 0.
- R8: A sink whose selector holds pad code p+1 registers `pad_in[p]` one clock later, but only if pad p's input-enable bit is set. Otherwise the sink reads 0.
- R9: Several sinks that select the same pad all receive its value in the same cycle.
- R10: A sink selector holding 0 or any non-pad code holds the sink at 0.
- R11: `pad_pu` and `pad_pd` follow the pull-up and pull-down bits of each pad's control register.
- R12: A GPIO bit that drives a pad and also selects that pad as its input reads back the driven level. This holds only when input enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address for register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| gpio_out | input | NUM_GPIO | GPIO port output bits (sources) |
| gpio_oe | input | NUM_GPIO | GPIO port output-enable bits |
| gpio_in | output | NUM_GPIO | GPIO port input bits (sinks) |
| periph_out | input | NUM_PERIPH_OUT | Peripheral outputs (sources) |
| periph_in | output | NUM_PERIPH_IN | Peripheral inputs (sinks) |
| pad_out | output | NUM_PADS | Pad output level |
| pad_oe | output | NUM_PADS | Pad output enable |
| pad_pu | output | NUM_PADS | Pull-up request per pad |
| pad_pd | output | NUM_PADS | Pull-down request per pad |
| pad_in | input | NUM_PADS | Level sensed at each pad |

## Verification
The hardest case to reach is read-back. Here a pad's level comes from the crossbar's own output and returns through the inbound path, so the check spans two register stages and depends on the output enable. The bench models each pad as driven by `pad_out` when `pad_oe` is set and by an external level otherwise. It then programs one GPIO bit both to drive a pad and to select that pad as its input. The stimulus table toggles that bit's data and output enable separately, so the read-back must follow the GPIO level only while the output is enabled. The same table fans one externally driven pad into three sinks at once.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  // Per-pad control word; ie lands on bit 0, pu on bit 1, pd on bit 2
  typedef struct packed {
    logic pd;
    logic pu;
    logic ie;
  } pad_ctl_t;

  localparam int PAD_STRIDE   = 8;
  localparam int CTL_OFFSET   = 4;
  localparam int PORT_STRIDE  = 64;
  localparam int SINK_STRIDE  = 4;
  localparam int MAX_PORT_BITS = PORT_STRIDE / SINK_STRIDE;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS    = 8,
  parameter int GPIO_PORTS  = 2,
  parameter int GPIO_WIDTH  = 16,
  parameter int NUM_PIN     = 4,
  parameter int SEL_W       = 6,
  parameter int ADDR_W      = 12,
  parameter int GSINK_BASE  = 'h100,
  parameter int PSINK_BASE  = 'h200
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic                                bus_we,
  input  logic [31:0]                         bus_wdata,
  output logic [31:0]                         bus_rdata,
  output logic [NUM_PADS-1:0][SEL_W-1:0]      pad_sel_o,
  output pad_ctl_t [NUM_PADS-1:0]             pad_ctl_o,
  output logic [GPIO_PORTS*GPIO_WIDTH-1:0][SEL_W-1:0] gsink_sel_o,
  output logic [NUM_PIN-1:0][SEL_W-1:0]       psink_sel_o
);
  localparam int NUM_GPIO = GPIO_PORTS * GPIO_WIDTH;

  logic [NUM_PADS-1:0][SEL_W-1:0] pad_sel_q;
  pad_ctl_t [NUM_PADS-1:0]        pad_ctl_q;
  logic [NUM_GPIO-1:0][SEL_W-1:0] gsink_sel_q;
  logic [NUM_PIN-1:0][SEL_W-1:0]  psink_sel_q;
  logic [31:0]                    rd_next;
  logic                           unused_wdata;

  assign unused_wdata = ^bus_wdata[31:SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_sel_q   <= '0;
      pad_ctl_q   <= '0;
      gsink_sel_q <= '0;
      psink_sel_q <= '0;
    end else if (bus_we) begin
      for (int p = 0; p < NUM_PADS; p++) begin
        if (bus_addr == ADDR_W'(PAD_STRIDE * p))
          pad_sel_q[p] <= bus_wdata[SEL_W-1:0];
        if (bus_addr == ADDR_W'(PAD_STRIDE * p + CTL_OFFSET))
          pad_ctl_q[p] <= pad_ctl_t'(bus_wdata[2:0]);
      end
      for (int n = 0; n < GPIO_PORTS; n++)
        for (int b = 0; b < GPIO_WIDTH; b++)
          if (bus_addr == ADDR_W'(GSINK_BASE + PORT_STRIDE * n + SINK_STRIDE * b))
            gsink_sel_q[n*GPIO_WIDTH+b] <= bus_wdata[SEL_W-1:0];
      for (int k = 0; k < NUM_PIN; k++)
        if (bus_addr == ADDR_W'(PSINK_BASE + SINK_STRIDE * k))
          psink_sel_q[k] <= bus_wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (bus_addr == ADDR_W'(PAD_STRIDE * p))
        rd_next = 32'(pad_sel_q[p]);
      if (bus_addr == ADDR_W'(PAD_STRIDE * p + CTL_OFFSET))
        rd_next = 32'(pad_ctl_q[p]);
    end
    for (int n = 0; n < GPIO_PORTS; n++)
      for (int b = 0; b < GPIO_WIDTH; b++)
        if (bus_addr == ADDR_W'(GSINK_BASE + PORT_STRIDE * n + SINK_STRIDE * b))
          rd_next = 32'(gsink_sel_q[n*GPIO_WIDTH+b]);
    for (int k = 0; k < NUM_PIN; k++)
      if (bus_addr == ADDR_W'(PSINK_BASE + SINK_STRIDE * k))
        rd_next = 32'(psink_sel_q[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign pad_sel_o   = pad_sel_q;
  assign pad_ctl_o   = pad_ctl_q;
  assign gsink_sel_o = gsink_sel_q;
  assign psink_sel_o = psink_sel_q;

  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == '0) |=> (pad_sel_o[0] == $past(bus_wdata[SEL_W-1:0]))); // R2
  AST_GSINK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(GSINK_BASE)) |=> (gsink_sel_o[0] == $past(bus_wdata[SEL_W-1:0]))); // R3
endmodule

// File: rtl/pinmux_pad_route.sv
module pinmux_pad_route #(
  parameter int NUM_PADS = 8,
  parameter int NUM_GPIO = 32,
  parameter int NUM_POUT = 4,
  parameter int SEL_W    = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PADS-1:0][SEL_W-1:0] sel_i,
  input  logic [NUM_GPIO-1:0]            gpio_out_i,
  input  logic [NUM_GPIO-1:0]            gpio_oe_i,
  input  logic [NUM_POUT-1:0]            periph_out_i,
  output logic [NUM_PADS-1:0]            pad_out_o,
  output logic [NUM_PADS-1:0]            pad_oe_o
);
  localparam int GPIO_CODE0   = NUM_PADS + 1;
  localparam int PERIPH_CODE0 = NUM_PADS + 1 + NUM_GPIO;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic drv, en;

    always_comb begin
      drv = 1'b0;
      en  = 1'b0;
      for (int j = 0; j < NUM_GPIO; j++)
        if (sel_i[p] == SEL_W'(GPIO_CODE0 + j)) begin
          drv = gpio_out_i[j];
          en  = gpio_oe_i[j];
        end
      for (int k = 0; k < NUM_POUT; k++)
        if (sel_i[p] == SEL_W'(PERIPH_CODE0 + k)) begin
          drv = periph_out_i[k];
          en  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out_o[p] <= 1'b0;
        pad_oe_o[p]  <= 1'b0;
      end else begin
        pad_out_o[p] <= drv;
        pad_oe_o[p]  <= en;
      end
    end

    AST_PAD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (sel_i[p] == '0) |=> (!pad_oe_o[p] && !pad_out_o[p])); // R7

    for (genvar k = 0; k < NUM_POUT; k++) begin : g_pchk
      AST_PERIPH_OE: assert property (@(posedge clk) disable iff (rst)
        (sel_i[p] == SEL_W'(PERIPH_CODE0 + k)) |=>
          (pad_oe_o[p] && pad_out_o[p] == $past(periph_out_i[k]))); // R6
    end

    for (genvar j = 0; j < NUM_GPIO; j++) begin : g_gchk
      AST_GPIO_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (sel_i[p] == SEL_W'(GPIO_CODE0 + j)) |=>
          (pad_oe_o[p] == $past(gpio_oe_i[j]) && pad_out_o[p] == $past(gpio_out_i[j]))); // R5
    end
  end
endmodule

// File: rtl/pinmux_sink_route.sv
module pinmux_sink_route #(
  parameter int NUM_SINKS = 32,
  parameter int NUM_PADS  = 8,
  parameter int SEL_W     = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SINKS-1:0][SEL_W-1:0] sel_i,
  input  logic [NUM_PADS-1:0]             pad_in_i,
  input  logic [NUM_PADS-1:0]             pad_ie_i,
  output logic [NUM_SINKS-1:0]            sink_o
);
  for (genvar s = 0; s < NUM_SINKS; s++) begin : g_sink
    logic val;

    always_comb begin
      val = 1'b0;
      for (int p = 0; p < NUM_PADS; p++)
        if (sel_i[s] == SEL_W'(p + 1))
          val = pad_in_i[p] & pad_ie_i[p];
    end

    always_ff @(posedge clk) begin
      if (rst) sink_o[s] <= 1'b0;
      else     sink_o[s] <= val;
    end

    AST_SINK_UNSEL: assert property (@(posedge clk) disable iff (rst)
      (sel_i[s] == '0) |=> !sink_o[s]); // R10

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_ichk
      AST_IE_GATE: assert property (@(posedge clk) disable iff (rst)
        (sel_i[s] == SEL_W'(p + 1) && !pad_ie_i[p]) |=> !sink_o[s]); // R8
    end
  end
endmodule

// File: rtl/pinmux_xbar.sv
module pinmux_xbar
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS       = 8,
  parameter int GPIO_PORTS     = 2,
  parameter int GPIO_WIDTH     = 16,
  parameter int NUM_PERIPH_OUT = 4,
  parameter int NUM_PERIPH_IN  = 4,
  parameter int ADDR_W         = 12,
  parameter int GSINK_BASE     = 'h100,
  parameter int PSINK_BASE     = 'h200,
  localparam int NUM_GPIO      = GPIO_PORTS * GPIO_WIDTH,
  localparam int NUM_CODES     = 1 + NUM_PADS + NUM_GPIO + NUM_PERIPH_OUT,
  localparam int SEL_W         = $clog2(NUM_CODES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_GPIO-1:0]       gpio_out,
  input  logic [NUM_GPIO-1:0]       gpio_oe,
  output logic [NUM_GPIO-1:0]       gpio_in,
  input  logic [NUM_PERIPH_OUT-1:0] periph_out,
  output logic [NUM_PERIPH_IN-1:0]  periph_in,
  output logic [NUM_PADS-1:0]       pad_out,
  output logic [NUM_PADS-1:0]       pad_oe,
  output logic [NUM_PADS-1:0]       pad_pu,
  output logic [NUM_PADS-1:0]       pad_pd,
  input  logic [NUM_PADS-1:0]       pad_in
);
  logic [NUM_PADS-1:0][SEL_W-1:0]      pad_sel;
  pad_ctl_t [NUM_PADS-1:0]             pad_ctl;
  logic [NUM_GPIO-1:0][SEL_W-1:0]      gsink_sel;
  logic [NUM_PERIPH_IN-1:0][SEL_W-1:0] psink_sel;
  logic [NUM_PADS-1:0]                 pad_ie;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_ctl
    assign pad_ie[p] = pad_ctl[p].ie;
    assign pad_pu[p] = pad_ctl[p].pu;
    assign pad_pd[p] = pad_ctl[p].pd;
  end

  pinmux_regs #(
    .NUM_PADS(NUM_PADS), .GPIO_PORTS(GPIO_PORTS), .GPIO_WIDTH(GPIO_WIDTH),
    .NUM_PIN(NUM_PERIPH_IN), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .GSINK_BASE(GSINK_BASE), .PSINK_BASE(PSINK_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_sel_o(pad_sel), .pad_ctl_o(pad_ctl),
    .gsink_sel_o(gsink_sel), .psink_sel_o(psink_sel)
  );

  pinmux_pad_route #(
    .NUM_PADS(NUM_PADS), .NUM_GPIO(NUM_GPIO), .NUM_POUT(NUM_PERIPH_OUT), .SEL_W(SEL_W)
  ) u_pads (
    .clk(clk), .rst(rst), .sel_i(pad_sel), .gpio_out_i(gpio_out),
    .gpio_oe_i(gpio_oe), .periph_out_i(periph_out),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  pinmux_sink_route #(
    .NUM_SINKS(NUM_GPIO), .NUM_PADS(NUM_PADS), .SEL_W(SEL_W)
  ) u_gsink (
    .clk(clk), .rst(rst), .sel_i(gsink_sel), .pad_in_i(pad_in),
    .pad_ie_i(pad_ie), .sink_o(gpio_in)
  );

  pinmux_sink_route #(
    .NUM_SINKS(NUM_PERIPH_IN), .NUM_PADS(NUM_PADS), .SEL_W(SEL_W)
  ) u_psink (
    .clk(clk), .rst(rst), .sel_i(psink_sel), .pad_in_i(pad_in),
    .pad_ie_i(pad_ie), .sink_o(periph_in)
  );

  AST_PULL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(CTL_OFFSET)) |=>
      (pad_pu[0] == $past(bus_wdata[1]) && pad_pd[0] == $past(bus_wdata[2]))); // R11
endmodule

// File: tb/pinmux_xbar_bench.sv
`timescale 1ns/1ps
module pinmux_xbar_bench;
  localparam int P = 8, G = 32, FO = 4, FI = 4, AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [G-1:0] gpio_out = '0, gpio_oe = '0, gpio_in;
  logic [FO-1:0] periph_out = '0;
  logic [FI-1:0] periph_in;
  logic [P-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_in, ext = '0;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  pinmux_xbar u_pinmux_xbar (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in),
    .periph_out(periph_out), .periph_in(periph_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_in(pad_in)
  );

  // stimulus {ext3, periph0, oe17, oe0, gpio17, gpio0}
  // expected {periph_in1, periph_in0, gpio_in6, gpio_in5, gpio_in0, pad_oe[2:0], pad_out[2:0]}
  localparam logic [16:0] TBL [6] = '{
    {6'b000000, 11'b00000_100_000},
    {6'b000101, 11'b00001_101_001},
    {6'b001011, 11'b00000_110_011},
    {6'b110000, 11'b11110_100_100},
    {6'b111111, 11'b11111_111_111},
    {6'b100100, 11'b01110_101_000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = AW'(a); bus_wdata = 32'(d); bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input int exp);
    bus_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    chk(req, bus_rdata, 32'(exp));
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 pulls", 32'({pad_pu, pad_pd}), 0);
    chk("R1 gpio_in", gpio_in, 0);
    chk("R1 periph_in", 32'(periph_in), 0);
    rd_chk("R1 pad0 sel", 'h00, 0);
    rd_chk("R1 gsink0 sel", 'h100, 0);

    // R4 codes: pad p -> p+1, gpio j -> 9+j, periph k -> 41+k
    wr('h00, 9);  wr('h04, 1);
    wr('h08, 26);
    wr('h10, 41); wr('h14, 7);
    wr('h1C, 1);
    wr('h100, 1); wr('h114, 4); wr('h118, 4);
    wr('h200, 4); wr('h204, 3);
    rd_chk("R2 pad1 sel readback", 'h08, 26);
    rd_chk("R2 pad2 ctl readback", 'h14, 7);
    rd_chk("R3 gpio port0 bit5 sel", 'h114, 4);
    rd_chk("R3 periph in1 sel", 'h204, 3);
    rd_chk("R2 unmapped", 'h300, 0);
    rd_chk("R3 unwritten sink", 'h104, 0);
    chk("R11 pull bits", 32'({pad_pu[2], pad_pd[2], pad_pu[0], pad_pd[0]}), 32'b1100);

    // Table: R4 R5 R6 R8 R9 R12
    for (int i = 0; i < 6; i++) begin
      gpio_out[0] = TBL[i][11]; gpio_out[17] = TBL[i][12];
      gpio_oe[0]  = TBL[i][13]; gpio_oe[17]  = TBL[i][14];
      periph_out[0] = TBL[i][15]; ext[3] = TBL[i][16];
      settle();
      chk($sformatf("R4/R5/R6/R8/R9/R12 row%0d", i),
          32'({periph_in[1], periph_in[0], gpio_in[6], gpio_in[5], gpio_in[0],
               pad_oe[2:0], pad_out[2:0]}), 32'(TBL[i][10:0]));
    end

    // R8: input enable cleared blocks pad 3
    ext[3] = 1'b1;
    wr('h1C, 0); settle();
    chk("R8 ie off", 32'({gpio_in[6], gpio_in[5], periph_in[0]}), 0);
    wr('h1C, 1); settle();
    chk("R9 ie on fanout", 32'({gpio_in[6], gpio_in[5], periph_in[0]}), 32'b111);

    // R10: non-pad code on a sink
    wr('h118, 9); settle();
    chk("R10 gpio code on sink", 32'({gpio_in[6], gpio_in[5]}), 32'b01);
    wr('h118, 0); settle();
    chk("R10 zero code on sink", 32'(gpio_in[6]), 0);

    // R7: non-source codes on a pad selector
    gpio_out[17] = 1'b1; gpio_oe[17] = 1'b1;
    wr('h08, 3); settle();
    chk("R7 pad code on pad", 32'({pad_oe[1], pad_out[1]}), 0);
    wr('h08, 60); settle();
    chk("R7 unused code on pad", 32'({pad_oe[1], pad_out[1]}), 0);
    wr('h08, 26); settle();
    chk("R5 restored drive", 32'({pad_oe[1], pad_out[1]}), 32'b11);
    wr('h08, 0); settle();
    chk("R7 zero code on pad", 32'({pad_oe[1], pad_out[1]}), 0);

    // R11: pull bits clear
    wr('h14, 1); settle();
    chk("R11 pulls cleared", 32'({pad_pu[2], pad_pd[2]}), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule